// File: doc/BRIEF.md
# Pseudo Fault Injection Unit

This unit lets fault-handling software be exercised without damaging any stored data. Software arms it with a countdown value and a set of error classes it wishes to see. The unit then watches the stream of protected-memory accesses, each marked as a data or a tag access. Once the countdown is used up, the next access that suits the chosen class reports a synthetic error. The stored data and the real checker are never touched: the injected error exists only on the report outputs.

A real error flagged by the checker for the same access is still reported. The unit merges the two and reports the more severe class, ranked uncontainable over recoverable over deferred over corrected. Each report raises an interrupt request for one cycle. A sticky status register holds the class of the latest report until software clears it. The access stream is observe-only: every strobe is accepted in its cycle and the unit applies no back-pressure to it.

Top module: `pfi_unit`

## Requirements
- R1: After reset, err_valid, irq, stat_valid and armed are 0, and err_class and stat_class are 0.
- R2: An access is eligible only when acc_valid, det_en and inj_allow are all 1 and at least one type_en bit is set. Accesses that are not eligible neither fire nor change the countdown.
- R3: Each eligible access while armed with a nonzero count decrements the count by one. The eligible access that finds the count at zero fires the injection, so a loaded value of N fires on the (N+1)th eligible access.
- R4: The injection fires only once. Firing clears armed. A pulse on arm sets armed and loads cd_value, and it takes priority over any access in the same cycle.
- R5: Class codes are 0 corrected, 1 deferred, 2 recoverable, 3 uncontainable, and type_en bit k enables class k. The injected class is the highest enabled code. A deferred injection is eligible only on data accesses (acc_is_tag=0). An uncontainable injection is eligible only on tag accesses. The other two classes are eligible on either kind.
- R6: A real error is taken only with acc_valid and det_en set. chk_double selects class 3 on a tag access and class 1 on a data access. Otherwise chk_single selects class 0. chk_double takes precedence over chk_single.
- R7: One cycle after an access with a real error or a firing injection, err_valid and irq are 1 for one cycle. err_class then holds the higher code of the two, and it is 0 when err_valid is 0.
- R8: Each report sets stat_valid and loads stat_class with the reported code. A stat_clr pulse clears stat_valid, but a report in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_en | input | 1 | Error detection and reporting enable |
| inj_allow | input | 1 | Injection permission |
| type_en | input | 4 | Per-class injection enable, bit k = class k |
| arm | input | 1 | Pulse: load countdown and arm |
| cd_value | input | CNT_W | Countdown load value |
| acc_valid | input | 1 | Access strobe |
| acc_is_tag | input | 1 | Access targets tag (1) or data (0) |
| chk_single | input | 1 | Checker: single-bit error on this access |
| chk_double | input | 1 | Checker: double-bit error on this access |
| stat_clr | input | 1 | Write-one-to-clear pulse for status |
| err_valid | output | 1 | Error report strobe |
| err_class | output | 2 | Reported class code |
| irq | output | 1 | Interrupt request pulse |
| stat_valid | output | 1 | Sticky status valid |
| stat_class | output | 2 | Class of last report |
| armed | output | 1 | Injection armed |

## Verification
The assertions assume that chk_single and chk_double only matter in cycles with acc_valid, and that arm and stat_clr are single-cycle pulses from software. The stimulus drives every input away from the clock edge. It keeps the checker inputs random even without acc_valid, so the gating itself is tested. It uses small countdown values so that fires happen often. It mixes tag and data accesses, so that both the eligibility rules and the coincident-error merge are reached many times.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  localparam int NCLS = 4;
  localparam int CLS_W = $clog2(NCLS);
  typedef enum logic [CLS_W-1:0] {
    CLS_CORR   = 2'd0,
    CLS_DEFER  = 2'd1,
    CLS_RECOV  = 2'd2,
    CLS_UNCONT = 2'd3
  } err_cls_e;
endpackage

// File: rtl/pfi_classify.sv
module pfi_classify
  import pfi_pkg::*;
(
  input  logic            acc_valid,
  input  logic            acc_is_tag,
  input  logic            det_en,
  input  logic            inj_allow,
  input  logic [NCLS-1:0] type_en,
  input  logic            chk_single,
  input  logic            chk_double,
  output logic            real_v,
  output err_cls_e        real_cls,
  output err_cls_e        inj_cls,
  output logic            inj_elig
);
  logic [CLS_W-1:0] pick;
  logic             any_en;

  // highest enabled class code wins
  always_comb begin
    pick   = '0;
    any_en = 1'b0;
    for (int k = 0; k < NCLS; k++) begin
      if (type_en[k]) begin
        pick   = CLS_W'(k);
        any_en = 1'b1;
      end
    end
  end

  assign inj_cls = err_cls_e'(pick);

  always_comb begin
    inj_elig = acc_valid && det_en && inj_allow && any_en;
    if (inj_cls == CLS_DEFER  &&  acc_is_tag) inj_elig = 1'b0;
    if (inj_cls == CLS_UNCONT && !acc_is_tag) inj_elig = 1'b0;
  end

  assign real_v = acc_valid && det_en && (chk_single || chk_double);

  always_comb begin
    if (chk_double) real_cls = acc_is_tag ? CLS_UNCONT : CLS_DEFER;
    else            real_cls = CLS_CORR;
  end
endmodule

// File: rtl/pfi_countdown.sv
module pfi_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [CNT_W-1:0] cd_value,
  input  logic             elig,
  output logic             fire,
  output logic             armed
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign fire    = elig && armed_q && at_zero;
  assign armed   = armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (arm) begin
      armed_q <= 1'b1;
      cnt_q   <= cd_value;
    end else if (elig && armed_q) begin
      if (at_zero) armed_q <= 1'b0;
      else         cnt_q   <= cnt_q - 1'b1;
    end
  end

  // R3: an eligible armed access with a nonzero count consumes exactly one step
  a_r3_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (elig && armed_q && !at_zero && !arm) |=> (cnt_q == $past(cnt_q) - 1'b1) && armed_q);

  // R4: firing disarms unless re-armed in the same cycle
  a_r4_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !arm) |=> !armed_q);

  // R4: arm pulse loads the count
  a_r4_arm_load: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> armed_q && (cnt_q == $past(cd_value)));

  // R2: without eligibility the state holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!elig && !arm) |=> $stable(cnt_q) && $stable(armed_q));
endmodule

// File: rtl/pfi_report.sv
module pfi_report
  import pfi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     real_v,
  input  err_cls_e real_cls,
  input  logic     fire,
  input  err_cls_e inj_cls,
  input  logic     stat_clr,
  output logic     err_valid,
  output err_cls_e err_class,
  output logic     irq,
  output logic     stat_valid,
  output err_cls_e stat_class
);
  logic     rep;
  err_cls_e merged;

  assign rep = real_v || fire;

  always_comb begin
    merged = CLS_CORR;
    if (real_v) merged = real_cls;
    if (fire && (!real_v || inj_cls > real_cls)) merged = inj_cls;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_valid  <= 1'b0;
      err_class  <= CLS_CORR;
      irq        <= 1'b0;
      stat_valid <= 1'b0;
      stat_class <= CLS_CORR;
    end else begin
      err_valid <= rep;
      irq       <= rep;
      err_class <= rep ? merged : CLS_CORR;
      if (rep) begin
        stat_valid <= 1'b1;
        stat_class <= merged;
      end else if (stat_clr) begin
        stat_valid <= 1'b0;
      end
    end
  end

  // R7: a real error is never masked and never downgraded
  a_r7_real_kept: assert property (@(posedge clk) disable iff (!rst_n)
    real_v |=> err_valid && irq && (err_class >= $past(real_cls)));

  // R7: an injection is never downgraded
  a_r7_inj_kept: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> err_valid && (err_class >= $past(inj_cls)));

  // R8: clear without report drops status
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !rep) |=> !stat_valid);

  // R8: status mirrors each report
  a_r8_track: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |-> stat_valid && (stat_class == err_class));
endmodule

// File: rtl/pfi_unit.sv
module pfi_unit
  import pfi_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en,
  input  logic             inj_allow,
  input  logic [3:0]       type_en,
  input  logic             arm,
  input  logic [CNT_W-1:0] cd_value,
  input  logic             acc_valid,
  input  logic             acc_is_tag,
  input  logic             chk_single,
  input  logic             chk_double,
  input  logic             stat_clr,
  output logic             err_valid,
  output logic [1:0]       err_class,
  output logic             irq,
  output logic             stat_valid,
  output logic [1:0]       stat_class,
  output logic             armed
);
  logic     real_v, inj_elig, fire;
  err_cls_e real_cls, inj_cls, rep_cls, st_cls;

  pfi_classify u_cls (
    .acc_valid(acc_valid), .acc_is_tag(acc_is_tag), .det_en(det_en),
    .inj_allow(inj_allow), .type_en(type_en), .chk_single(chk_single),
    .chk_double(chk_double), .real_v(real_v), .real_cls(real_cls),
    .inj_cls(inj_cls), .inj_elig(inj_elig)
  );

  pfi_countdown #(.CNT_W(CNT_W)) u_cd (
    .clk(clk), .rst_n(rst_n), .arm(arm), .cd_value(cd_value),
    .elig(inj_elig), .fire(fire), .armed(armed)
  );

  pfi_report u_rep (
    .clk(clk), .rst_n(rst_n), .real_v(real_v), .real_cls(real_cls),
    .fire(fire), .inj_cls(inj_cls), .stat_clr(stat_clr),
    .err_valid(err_valid), .err_class(rep_cls), .irq(irq),
    .stat_valid(stat_valid), .stat_class(st_cls)
  );

  assign err_class  = rep_cls;
  assign stat_class = st_cls;

  // R7: report pulses last one cycle unless a new cause is present
  a_r7_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!real_v && !fire) |=> !err_valid && !irq && (err_class == 2'd0));

  // R2: injection cannot fire with detection or permission off
  a_r2_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en || !inj_allow) |-> !fire);
endmodule

// File: tb/test_pfi_unit.sv
module test_pfi_unit;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 0, rst_n = 0;
  logic det_en = 0, inj_allow = 0, arm = 0, acc_valid = 0, acc_is_tag = 0;
  logic chk_single = 0, chk_double = 0, stat_clr = 0;
  logic [3:0] type_en = 0;
  logic [CNT_W-1:0] cd_value = 0;
  logic err_valid, irq, stat_valid, armed;
  logic [1:0] err_class, stat_class;

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model state
  bit m_armed = 0;
  int m_cnt = 0;
  bit m_sv = 0;
  logic [1:0] m_sc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfi_unit #(.CNT_W(CNT_W)) i_pfi_unit (
    .clk(clk), .rst_n(rst_n), .det_en(det_en), .inj_allow(inj_allow),
    .type_en(type_en), .arm(arm), .cd_value(cd_value), .acc_valid(acc_valid),
    .acc_is_tag(acc_is_tag), .chk_single(chk_single), .chk_double(chk_double),
    .stat_clr(stat_clr), .err_valid(err_valid), .err_class(err_class),
    .irq(irq), .stat_valid(stat_valid), .stat_class(stat_class), .armed(armed)
  );

  function automatic int top_cls(logic [3:0] en);
    int c = -1;
    for (int k = 0; k < 4; k++) if (en[k]) c = k;
    return c;
  endfunction

  function automatic bit is_elig(int c, bit tag);
    if (c < 0) return 0;
    if (c == 1) return !tag;
    if (c == 3) return tag;
    return 1;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp, string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // drive the current inputs for one cycle and check the registered outcome
  task automatic step(string tag);
    int ic, rc;
    bit en, elig, fire, rv, ev;
    logic [1:0] ecls;
    ic   = top_cls(type_en);
    en   = acc_valid && det_en && inj_allow;
    elig = en && is_elig(ic, acc_is_tag);
    fire = elig && m_armed && (m_cnt == 0);
    rv   = acc_valid && det_en && (chk_single || chk_double);
    rc   = chk_double ? (acc_is_tag ? 3 : 1) : 0;
    ev   = rv || fire;
    ecls = 0;
    if (rv) ecls = 2'(rc);
    if (fire && (!rv || ic > rc)) ecls = 2'(ic);
    if (arm) begin m_armed = 1; m_cnt = int'(cd_value); end
    else if (elig && m_armed) begin
      if (m_cnt == 0) m_armed = 0; else m_cnt--;
    end
    if (ev) begin m_sv = 1; m_sc = ecls; end
    else if (stat_clr) m_sv = 0;
    @(posedge clk); #1;
    check(tag, 8'(err_valid), 8'(ev), "err_valid");
    check(tag, 8'(irq), 8'(ev), "irq");
    check(tag, 8'(err_class), 8'(ecls), "err_class");
    check(tag, 8'(stat_valid), 8'(m_sv), "stat_valid");
    check(tag, 8'(stat_class), 8'(m_sc), "stat_class");
    check(tag, 8'(armed), 8'(m_armed), "armed");
    arm = 0; stat_clr = 0; acc_valid = 0; chk_single = 0; chk_double = 0;
  endtask

  task automatic access(bit tag, bit s, bit d, string t);
    acc_valid = 1; acc_is_tag = tag; chk_single = s; chk_double = d;
    step(t);
  endtask

  task automatic do_arm(int v, string t);
    arm = 1; cd_value = CNT_W'(v);
    step(t);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    check("R1", 8'(err_valid), 0, "err_valid");
    check("R1", 8'(irq), 0, "irq");
    check("R1", 8'(stat_valid), 0, "stat_valid");
    check("R1", 8'(armed), 0, "armed");
    check("R1", 8'(err_class), 0, "err_class");
    check("R1", 8'(stat_class), 0, "stat_class");
    rst_n = 1;
    #(CLK_PERIOD);

    // R2: gating off -> no fire, no decrement
    det_en = 1; inj_allow = 0; type_en = 4'b0001;
    do_arm(0, "R2");
    repeat (3) access(0, 0, 0, "R2");
    inj_allow = 1; type_en = 4'b0000;
    access(0, 0, 0, "R2");
    // R3: zero fires on next eligible access; R4 one-shot
    type_en = 4'b0001;
    access(0, 0, 0, "R3");
    access(0, 0, 0, "R4");
    // R3: count 2 fires on third eligible access
    do_arm(2, "R3");
    repeat (3) access(1, 0, 0, "R3");
    // R4: arm wins over access in the same cycle
    acc_valid = 1; arm = 1; cd_value = 1; step("R4");
    // R5: deferred only on data
    type_en = 4'b0011; do_arm(0, "R5");
    access(1, 0, 0, "R5");
    access(0, 0, 0, "R5");
    // R5: uncontainable only on tag
    type_en = 4'b1001; do_arm(0, "R5");
    access(0, 0, 0, "R5");
    access(1, 0, 0, "R5");
    // R6: real classification
    access(0, 1, 0, "R6");
    access(1, 0, 1, "R6");
    access(0, 1, 1, "R6");
    det_en = 0; access(1, 1, 1, "R6"); det_en = 1;
    // R7: merge, injected recoverable vs real deferred and uncontainable
    type_en = 4'b0100; do_arm(0, "R7");
    access(0, 0, 1, "R7");
    do_arm(0, "R7");
    access(1, 0, 1, "R7");
    // R8: clear, and report beats clear
    stat_clr = 1; step("R8");
    stat_clr = 1; acc_valid = 1; chk_single = 1; step("R8");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      det_en     = ($urandom % 8) != 0;
      inj_allow  = ($urandom % 6) != 0;
      type_en    = 4'($urandom);
      arm        = ($urandom % 10) == 0;
      cd_value   = CNT_W'($urandom % 5);
      acc_valid  = ($urandom % 3) != 0;
      acc_is_tag = 1'($urandom);
      chk_single = ($urandom % 7) == 0;
      chk_double = ($urandom % 9) == 0;
      stat_clr   = ($urandom % 5) == 0;
      step("R7");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule